// File: doc/BRIEF.md
# Trigger and Calibrate Sequencer

This block is the command source for a set of downstream readout slaves. It turns trigger, calibrate and pipeline-synchronise requests into single-cycle command pulses, each fanned out to the slaves enabled in a slave mask. The requests come from one of two places, picked by a mode input. In local mode they come from host command bits. In global mode they come from single-cycle pulses delivered by an external trigger source. Local mode acts on the rising edge of each host command bit. The host therefore sets a bit and then clears it, and the clearing write does nothing.

A trigger request raises `accept`. The trigger is issued once the external `busy_in` input is low, and `accept` drops on that same edge. A host that waits for `accept` to clear before its next request cannot lose a trigger. A calibrate request produces a one-cycle test pulse at once. A programmable delay later it produces a trigger, and `cal_busy` covers the whole sequence. Every issued trigger carries a readout-type code and advances a hardware trigger number. Requests that arrive while a trigger or a calibrate sequence is outstanding are dropped.

Top module: `trigcal_seq`

## Requirements
- R1: With `mode_global` = 1, requests come only from `ext_trig`, `ext_cal` and `ext_init`, and the host bits are ignored. With `mode_global` = 0, requests come only from the host bits, and the external pulses are ignored.
- R2: A host bit requests its command only on a 0-to-1 transition. Holding the bit at 1 or clearing it to 0 has no effect.
- R3: A trigger request sets `accept` on the next clock edge. `accept` clears on the edge where `trig_out` goes to `slave_mask` for exactly one cycle.
- R4: A calibrate request drives `tp_out` = `slave_mask` for one cycle, starting at the next edge. When `busy_in` stays low, `trig_out` follows `cal_delay`+1 cycles after `tp_out`.
- R5: `cal_busy` rises on the same edge as `tp_out`. It stays high until the edge on which the calibrate trigger appears on `trig_out`.
- R6: `trig_num` increments by one, wrapping, on every issued trigger, including the trigger inside a calibrate sequence.
- R7: A synchronise request (host sync edge or `ext_init`) drives `sync_out` = `slave_mask` for one cycle at the next edge. Neither `busy_in`, `accept` nor `cal_busy` blocks it.
- R8: Trigger and calibrate requests are dropped while `accept` or `cal_busy` is high. When both requests arrive in the same cycle, calibrate wins and the trigger is dropped.
- R9: While `busy_in` is high, no trigger is issued. A pending trigger goes out on the edge after the first cycle in which `busy_in` is low.
- R10: `rtype_in` is captured when a request is accepted. It appears on `rtype_out` at the edge its trigger is issued and is held until the next trigger.
- R11: All command outputs are gated bitwise by `slave_mask`. With a zero mask, a trigger still advances `trig_num`.
- R12: During and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_global | input | 1 | 1 = external command source, 0 = host bits |
| host_trig | input | 1 | Host trigger command bit (level) |
| host_cal | input | 1 | Host calibrate command bit (level) |
| host_sync | input | 1 | Host synchronise command bit (level) |
| ext_trig | input | 1 | External trigger pulse |
| ext_cal | input | 1 | External calibrate pulse |
| ext_init | input | 1 | External initialise pulse |
| busy_in | input | 1 | Downstream busy, stalls trigger issue |
| cal_delay | input | DLY_W | Test-pulse to trigger delay control |
| rtype_in | input | RT_W | Readout-type code for the next trigger |
| slave_mask | input | N_SLV | Per-slave command enable |
| accept | output | 1 | Trigger pending |
| cal_busy | output | 1 | Calibrate sequence running |
| trig_out | output | N_SLV | Per-slave trigger pulse |
| tp_out | output | N_SLV | Per-slave test pulse |
| sync_out | output | N_SLV | Per-slave pipeline synchronise pulse |
| rtype_out | output | RT_W | Readout type of the last trigger |
| trig_num | output | NUM_W | Trigger number |

## Verification
A request seen at edge E shows on `accept`, `cal_busy`, `tp_out` and `sync_out` after E. A plain trigger reaches `trig_out`, `rtype_out` and `trig_num` one edge after the first non-busy cycle that follows. The calibrate trigger lands `cal_delay`+1 edges after the test pulse. The bench drives inputs on the falling edge and keeps a cycle model that steps on the rising edge. Every registered output is compared on the following falling edge, so each result is checked in the exact cycle it is due. Directed sequences measure the calibrate gap, the busy stall and the dropped requests directly, as counts taken at the ports.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_WAIT = 1'b1
  } cal_st_e;
endpackage

// File: rtl/tcs_edge.sv
module tcs_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
#(
  parameter int RT_W  = 3,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic             cal_req,
  input  logic             busy_in,
  input  logic [DLY_W-1:0] cal_delay,
  input  logic [RT_W-1:0]  rtype_in,
  output logic             accept,
  output logic             cal_busy,
  output logic             issue,
  output logic             tp_fire,
  output logic [RT_W-1:0]  rt_hold
);
  cal_st_e          st_q, st_d;
  logic             acc_q, acc_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [RT_W-1:0]  rt_q, rt_d;
  logic             free, cal_go, trig_go, iss_t, iss_c;

  always_comb begin
    free    = !acc_q && (st_q == CS_IDLE);
    cal_go  = free & cal_req;
    trig_go = free & trig_req & ~cal_req;
    iss_t   = acc_q & ~busy_in;
    iss_c   = (st_q == CS_WAIT) && (cnt_q == '0) && !busy_in;

    acc_d = acc_q;
    st_d  = st_q;
    cnt_d = cnt_q;
    rt_d  = rt_q;

    if (trig_go)    acc_d = 1'b1;
    else if (iss_t) acc_d = 1'b0;

    case (st_q)
      CS_IDLE: begin
        if (cal_go) begin
          st_d  = CS_WAIT;
          cnt_d = cal_delay;
        end
      end
      CS_WAIT: begin
        if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else if (!busy_in) st_d = CS_IDLE;
      end
      default: st_d = CS_IDLE;
    endcase

    if (cal_go | trig_go) rt_d = rtype_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      acc_q <= 1'b0;
      cnt_q <= '0;
      rt_q  <= '0;
    end else begin
      st_q  <= st_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      rt_q  <= rt_d;
    end
  end

  assign accept   = acc_q;
  assign cal_busy = (st_q == CS_WAIT);
  assign issue    = iss_t | iss_c;
  assign tp_fire  = cal_go;
  assign rt_hold  = rt_q;
endmodule

// File: rtl/tcs_fanout.sv
module tcs_fanout #(
  parameter int N_SLV = 4,
  parameter int RT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             tp_fire,
  input  logic             sync_fire,
  input  logic [N_SLV-1:0] slave_mask,
  input  logic [RT_W-1:0]  rt_hold,
  output logic [N_SLV-1:0] trig_out,
  output logic [N_SLV-1:0] tp_out,
  output logic [N_SLV-1:0] sync_out,
  output logic [RT_W-1:0]  rtype_out
);
  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    logic trig_d, tp_d, sync_d;
    always_comb begin
      trig_d = issue     & slave_mask[s];
      tp_d   = tp_fire   & slave_mask[s];
      sync_d = sync_fire & slave_mask[s];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_out[s] <= 1'b0;
        tp_out[s]   <= 1'b0;
        sync_out[s] <= 1'b0;
      end else begin
        trig_out[s] <= trig_d;
        tp_out[s]   <= tp_d;
        sync_out[s] <= sync_d;
      end
    end
  end

  logic [RT_W-1:0] rto_d;
  always_comb rto_d = issue ? rt_hold : rtype_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtype_out <= '0;
    else        rtype_out <= rto_d;
  end
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_d;
  always_comb cnt_d = inc ? count + 1'b1 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/trigcal_seq.sv
module trigcal_seq #(
  parameter int N_SLV = 4,
  parameter int RT_W  = 3,
  parameter int NUM_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_global,
  input  logic             host_trig,
  input  logic             host_cal,
  input  logic             host_sync,
  input  logic             ext_trig,
  input  logic             ext_cal,
  input  logic             ext_init,
  input  logic             busy_in,
  input  logic [DLY_W-1:0] cal_delay,
  input  logic [RT_W-1:0]  rtype_in,
  input  logic [N_SLV-1:0] slave_mask,
  output logic             accept,
  output logic             cal_busy,
  output logic [N_SLV-1:0] trig_out,
  output logic [N_SLV-1:0] tp_out,
  output logic [N_SLV-1:0] sync_out,
  output logic [RT_W-1:0]  rtype_out,
  output logic [NUM_W-1:0] trig_num
);
  localparam int NCMD = 3;

  logic [NCMD-1:0] host_rise;
  logic            trig_req, cal_req, sync_req;
  logic            issue, tp_fire;
  logic [RT_W-1:0] rt_hold;

  tcs_edge #(.W(NCMD)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({host_sync, host_cal, host_trig}),
    .rise (host_rise)
  );

  always_comb begin
    if (mode_global) begin
      trig_req = ext_trig;
      cal_req  = ext_cal;
      sync_req = ext_init;
    end else begin
      trig_req = host_rise[0];
      cal_req  = host_rise[1];
      sync_req = host_rise[2];
    end
  end

  tcs_ctrl #(.RT_W(RT_W), .DLY_W(DLY_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_req (trig_req),
    .cal_req  (cal_req),
    .busy_in  (busy_in),
    .cal_delay(cal_delay),
    .rtype_in (rtype_in),
    .accept   (accept),
    .cal_busy (cal_busy),
    .issue    (issue),
    .tp_fire  (tp_fire),
    .rt_hold  (rt_hold)
  );

  tcs_fanout #(.N_SLV(N_SLV), .RT_W(RT_W)) u_fan (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .tp_fire   (tp_fire),
    .sync_fire (sync_req),
    .slave_mask(slave_mask),
    .rt_hold   (rt_hold),
    .trig_out  (trig_out),
    .tp_out    (tp_out),
    .sync_out  (sync_out),
    .rtype_out (rtype_out)
  );

  tcs_counter #(.W(NUM_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (issue),
    .count(trig_num)
  );
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
  parameter int N_SLV = 4,
  parameter int NUM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_in,
  input logic             accept,
  input logic             cal_busy,
  input logic [N_SLV-1:0] trig_out,
  input logic [N_SLV-1:0] tp_out,
  input logic [NUM_W-1:0] trig_num
);
  a_r3_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !busy_in) |=> !accept);

  a_r4_tp_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|tp_out) |=> !(|tp_out));

  a_r5_busy_with_tp: assert property (@(posedge clk) disable iff (!rst_n)
    (|tp_out) |-> cal_busy);

  a_r6_num_step: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_out) |-> (trig_num == $past(trig_num) + 1'b1));

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && cal_busy));

  a_r9_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> (trig_out == '0));
endmodule

bind trigcal_seq tcs_chk #(.N_SLV(N_SLV), .NUM_W(NUM_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_in (busy_in),
  .accept  (accept),
  .cal_busy(cal_busy),
  .trig_out(trig_out),
  .tp_out  (tp_out),
  .trig_num(trig_num)
);

// File: tb/trigcal_seq_tb_top.sv
module trigcal_seq_tb_top;
  localparam int  N_SLV  = 4;
  localparam int  RT_W   = 3;
  localparam int  NUM_W  = 16;
  localparam int  DLY_W  = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_global = 1'b0, host_trig = 1'b0, host_cal = 1'b0, host_sync = 1'b0;
  logic ext_trig = 1'b0, ext_cal = 1'b0, ext_init = 1'b0, busy_in = 1'b0;
  logic [DLY_W-1:0] cal_delay = '0;
  logic [RT_W-1:0]  rtype_in = '0;
  logic [N_SLV-1:0] slave_mask = '0;
  logic             accept, cal_busy;
  logic [N_SLV-1:0] trig_out, tp_out, sync_out;
  logic [RT_W-1:0]  rtype_out;
  logic [NUM_W-1:0] trig_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  trigcal_seq #(.N_SLV(N_SLV), .RT_W(RT_W), .NUM_W(NUM_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_global(mode_global),
    .host_trig(host_trig), .host_cal(host_cal), .host_sync(host_sync),
    .ext_trig(ext_trig), .ext_cal(ext_cal), .ext_init(ext_init),
    .busy_in(busy_in), .cal_delay(cal_delay), .rtype_in(rtype_in),
    .slave_mask(slave_mask), .accept(accept), .cal_busy(cal_busy),
    .trig_out(trig_out), .tp_out(tp_out), .sync_out(sync_out),
    .rtype_out(rtype_out), .trig_num(trig_num)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model stepped from the requirements.
  logic [2:0]       m_prev;
  logic             m_acc, m_cb;
  logic [DLY_W-1:0] m_cnt;
  logic [RT_W-1:0]  m_rt, m_rto;
  logic [N_SLV-1:0] m_trig, m_tp, m_sync;
  logic [NUM_W-1:0] m_num;

  function automatic logic busy_free(input logic acc, input logic cb);
    return !acc && !cb;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev <= '0; m_acc <= 0; m_cb <= 0; m_cnt <= '0; m_rt <= '0;
      m_rto <= '0; m_trig <= '0; m_tp <= '0; m_sync <= '0; m_num <= '0;
    end else begin : step
      logic [2:0] rise;
      logic treq, creq, sreq, it, ic, cgo, tgo;
      rise = {host_sync, host_cal, host_trig} & ~m_prev;
      treq = mode_global ? ext_trig : rise[0];
      creq = mode_global ? ext_cal  : rise[1];
      sreq = mode_global ? ext_init : rise[2];
      it   = m_acc & ~busy_in;
      ic   = m_cb && (m_cnt == 0) && !busy_in;
      cgo  = busy_free(m_acc, m_cb) & creq;
      tgo  = busy_free(m_acc, m_cb) & treq & ~creq;
      m_prev <= {host_sync, host_cal, host_trig};
      m_acc  <= tgo ? 1'b1 : (it ? 1'b0 : m_acc);
      m_cb   <= cgo ? 1'b1 : (ic ? 1'b0 : m_cb);
      m_cnt  <= cgo ? cal_delay : ((m_cb && m_cnt != 0) ? m_cnt - 1'b1 : m_cnt);
      m_rt   <= (cgo | tgo) ? rtype_in : m_rt;
      m_trig <= (it | ic) ? slave_mask : '0;
      m_tp   <= cgo ? slave_mask : '0;
      m_sync <= sreq ? slave_mask : '0;
      m_rto  <= (it | ic) ? m_rt : m_rto;
      m_num  <= (it | ic) ? m_num + 1'b1 : m_num;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 accept",           accept,    m_acc);
      chk("R5 cal_busy",         cal_busy,  m_cb);
      chk("R3 R11 trig_out",     trig_out,  m_trig);
      chk("R4 tp_out",           tp_out,    m_tp);
      chk("R7 sync_out",         sync_out,  m_sync);
      chk("R10 rtype_out",       rtype_out, m_rto);
      chk("R6 trig_num",         trig_num,  m_num);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 outputs in reset", {accept, cal_busy, trig_out, tp_out, sync_out, rtype_out, trig_num}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 outputs after reset", {accept, cal_busy, trig_out, tp_out, sync_out, rtype_out, trig_num}, '0);
    cmp_en = 1;

    // R4: calibrate gap with delay 5
    slave_mask = 4'hF; cal_delay = 8'd5; rtype_in = 3'd6;
    host_cal = 1'b1;
    do @(negedge clk); while (tp_out == '0);
    gap = 0;
    do begin @(negedge clk); gap++; end while (trig_out == '0);
    chk("R4 tp to trig gap", gap, 6);
    chk("R6 num after calibrate", trig_num, 1);
    chk("R10 rtype of calibrate", rtype_out, 3'd6);

    // R9 busy stall, R8 repeat request dropped
    host_cal = 1'b0; busy_in = 1'b1; host_trig = 1'b1; rtype_in = 3'd2;
    @(negedge clk);
    chk("R3 accept set", accept, 1);
    host_trig = 1'b0;
    @(negedge clk);
    host_trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no trigger while busy", trig_out, 0);
    busy_in = 1'b0;
    @(negedge clk);
    chk("R9 trigger after busy", trig_out, 4'hF);
    @(negedge clk);
    chk("R8 second request dropped", trig_num, 2);
    // R2: clearing write does nothing
    host_trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 clear has no effect", trig_num, 2);

    // R1: global mode ignores host bits
    mode_global = 1'b1; host_trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 host ignored in global", trig_num, 2);
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 external trigger counted", trig_num, 3);
    mode_global = 1'b0; host_trig = 1'b0;
    @(negedge clk);

    // R7: sync not blocked by busy
    busy_in = 1'b1; slave_mask = 4'h5; host_sync = 1'b1;
    @(negedge clk);
    chk("R7 sync while busy", sync_out, 4'h5);
    host_sync = 1'b0; busy_in = 1'b0;

    // R11: zero mask still counts
    slave_mask = 4'h0; host_trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 zero mask counts", trig_num, 4);
    host_trig = 1'b0; slave_mask = 4'hF;
    @(negedge clk);

    // Constrained random phase, checked each cycle against the model
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if ($urandom_range(199) == 0) mode_global = ~mode_global;
      if ($urandom_range(5) == 0) host_trig = ~host_trig;
      if ($urandom_range(7) == 0) host_cal  = ~host_cal;
      if ($urandom_range(9) == 0) host_sync = ~host_sync;
      ext_trig = ($urandom_range(9) == 0);
      ext_cal  = ($urandom_range(14) == 0);
      ext_init = ($urandom_range(19) == 0);
      busy_in  = ($urandom_range(4) == 0);
      cal_delay  = ($urandom_range(15) == 0) ? 8'($urandom_range(255)) : 8'($urandom_range(7));
      rtype_in   = RT_W'($urandom);
      slave_mask = N_SLV'($urandom);
    end
    @(negedge clk);
    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule